// File: doc/BRIEF.md
# H-bridge fixed-off-time current chopper

This block sequences the four gate enables of one full H-bridge: a high-side and a low-side enable for each of the two output legs (leg A drives the first motor terminal, leg B the second). Two command pins choose the bridge state: coast, forward, reverse or brake. The pins may also carry an external PWM waveform. Each leg passes through a dead-time sequencer, so a leg never switches straight from one FET to the other.

A trip pin comes from an off-chip comparator that watches the sense-resistor voltage. After the outputs enter a drive state, the trip pin is ignored for a blanking window. A trip accepted after that window forces slow decay: both high sides off and both low sides on. Slow decay lasts a fixed off time, and then the commanded drive state returns. A disable pin turns every FET off at once and holds the bridge idle while it stays asserted. A one-cycle event output marks each accepted trip.

The off time and the blanking window are given in nanoseconds and turned into clock cycles from the clock frequency parameter. The defaults are a 20 µs off time and a 3.75 µs blanking window. The dead time is given directly in cycles. The off time must be longer than the dead time plus one cycle.

Top module: `hbridge_chopper`

## Requirements
- R1: While reset is asserted, and after its release with the command pins at coast, all four gate enables and the event output are 0.
- R2: Command decode {in1_i,in2_i} once settled: 2'b00 all FETs off (coast); 2'b10 a_hi_o=1 and b_lo_o=1 (forward); 2'b01 a_lo_o=1 and b_hi_o=1 (reverse); 2'b11 a_lo_o=1 and b_lo_o=1 (brake). All other enables are 0.
- R3: On each leg, the high and low enables are never 1 together and never swap directly. Once a leg has been on, both of its enables stay 0 for at least DT cycles before either turns on again.
- R4: The trip pin is ignored for BLANK cycles, counted from the first cycle in which the outputs show a drive pattern. With the trip held high, chop_event_o rises BLANK+1 cycles after the high side turns on.
- R5: An accepted trip turns both high sides off and both low sides on. The driving high side stays off for exactly OFF+DT+1 cycles, after which the commanded drive returns.
- R6: chop_event_o is a single-cycle pulse, one for each accepted trip. It never fires when the trip pin is held low.
- R7: The trip pin has no effect in coast or brake. A trip held low never interrupts forward or reverse drive.
- R8: Chopping stays active while the command pins carry PWM: each drive pulse long enough to pass blanking gives one accepted trip.
- R9: A coast or brake command during the off time takes effect at once and clears the off-time timer. A later drive command is not held off by the time that remained.
- R10: disable_i high forces all four enables to 0 in the same cycle. While it is high, changes on the command and trip pins have no effect. After release, the outputs follow the current command.
- R11: Command and trip pins pass through a two-flop synchroniser. From an idle coast, a drive command set before a rising edge reaches the outputs after the third rising edge counted from that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in1_i | input | 1 | Command pin 1 (asynchronous) |
| in2_i | input | 1 | Command pin 2 (asynchronous) |
| disable_i | input | 1 | Forces all FETs off when high |
| trip_i | input | 1 | Current comparator trip (asynchronous), active high |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |
| chop_event_o | output | 1 | One-cycle pulse on each accepted trip |

## Verification
The bench builds the block with CLK_HZ=4_000_000 and DT=3. These values give an 80-cycle off time and a 15-cycle blanking window, so the cycle counts of blanking, event, off time and dead time can be predicted exactly from integer arithmetic. With these short windows, several back-to-back chop periods fit within a few hundred cycles. The same holds for five externally pulsed drive windows and for aborts in the middle of an off time. All sixteen ordered command transitions are swept, and a port monitor checks the dead-time gap on every turn-on.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // Command pair {pin1,pin2}; values follow the pin decode.
  typedef enum logic [1:0] {
    CMD_COAST = 2'b00,
    CMD_REV   = 2'b01,
    CMD_FWD   = 2'b10,
    CMD_BRAKE = 2'b11
  } cmd_e;

  // State applied to one leg.
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    prod = hz * ns + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  function automatic cmd_e decode_pins(logic p1, logic p2);
    return cmd_e'({p1, p2});
  endfunction

  // Requested state of one leg (is_b selects leg B).
  function automatic leg_e leg_target(cmd_e cmd, logic is_b, logic chop, logic halt);
    leg_e r;
    if (halt) r = LEG_OFF;
    else begin
      case (cmd)
        CMD_COAST: r = LEG_OFF;
        CMD_BRAKE: r = LEG_LO;
        CMD_FWD:   r = chop ? LEG_LO : (is_b ? LEG_LO : LEG_HI);
        CMD_REV:   r = chop ? LEG_LO : (is_b ? LEG_HI : LEG_LO);
        default:   r = LEG_OFF;
      endcase
    end
    return r;
  endfunction

  // A drive pattern has one leg high and the other low.
  function automatic logic is_drive(leg_e a, leg_e b);
    return ((a == LEG_HI) && (b == LEG_LO)) || ((a == LEG_LO) && (b == LEG_HI));
  endfunction

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/hbc_leg.sv
module hbc_leg
  import hbc_pkg::*;
#(
  parameter int DT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_e target_i,
  output logic hi_en_o,
  output logic lo_en_o,
  output leg_e state_o
);
  localparam int DTW = (DT < 1) ? 1 : $clog2(DT + 1);

  leg_e           cur;
  logic [DTW-1:0] dt_cnt;

  // Any on->off change arms the dead-time counter; turn-on waits for it to drain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= LEG_OFF;
      dt_cnt <= '0;
    end else if (cur != LEG_OFF) begin
      if (target_i != cur) begin
        cur    <= LEG_OFF;
        dt_cnt <= DTW'(DT);
      end
    end else if (dt_cnt != '0) begin
      dt_cnt <= dt_cnt - 1'b1;
    end else if (target_i != LEG_OFF) begin
      cur <= target_i;
    end
  end

  assign hi_en_o = (cur == LEG_HI);
  assign lo_en_o = (cur == LEG_LO);
  assign state_o = cur;

  // Independent gap observer for the dead-time property.
  logic           on_now;
  logic           on_q;
  logic           had_on_q;
  logic [DTW-1:0] gap_q;

  assign on_now = (cur != LEG_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      had_on_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      on_q     <= on_now;
      had_on_q <= had_on_q | on_now;
      if (on_now)                  gap_q <= '0;
      else if (gap_q != DTW'(DT))  gap_q <= gap_q + 1'b1;
    end
  end

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (on_now && !on_q && had_on_q) |-> (gap_q == DTW'(DT))); // R3
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (on_now && on_q) |-> (cur == $past(cur))); // R3
endmodule

// File: rtl/hbc_chop.sv
module hbc_chop
  import hbc_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 1000,
  parameter int unsigned BLANK_CYC = 188
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd_i,
  input  logic halt_i,
  input  logic trip_i,
  input  leg_e a_state_i,
  input  leg_e b_state_i,
  output logic chopping_o,
  output logic chop_event_o
);
  localparam int OW = $clog2(OFF_CYC + 1);
  localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
  localparam int RW = $clog2(BLANK_CYC + 2);

  logic [3:0]    pat;
  logic [3:0]    pat_q;
  logic          drive_now;
  logic          entry_now;
  logic          abort;
  logic          blank_open;
  logic          accept;
  logic [OW-1:0] off_cnt;
  logic [BW-1:0] blank_cnt;
  logic          event_q;

  assign pat        = {a_state_i, b_state_i};
  assign drive_now  = is_drive(a_state_i, b_state_i);
  assign entry_now  = drive_now && (pat != pat_q);
  assign abort      = halt_i || (cmd_i == CMD_COAST) || (cmd_i == CMD_BRAKE);
  assign blank_open = !entry_now && (blank_cnt == '0);
  assign accept     = trip_i && drive_now && blank_open && (off_cnt == '0) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q     <= {LEG_OFF, LEG_OFF};
      blank_cnt <= '0;
      off_cnt   <= '0;
      event_q   <= 1'b0;
    end else begin
      pat_q   <= pat;
      event_q <= accept;
      if (entry_now)              blank_cnt <= BW'(BLANK_CYC - 1);
      else if (blank_cnt != '0)   blank_cnt <= blank_cnt - 1'b1;
      if (abort)                  off_cnt <= '0;
      else if (accept)            off_cnt <= OW'(OFF_CYC);
      else if (off_cnt != '0)     off_cnt <= off_cnt - 1'b1;
    end
  end

  assign chopping_o   = (off_cnt != '0);
  assign chop_event_o = event_q;

  // Length of the current unbroken drive stretch, counted independently.
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_c;

  always_comb begin
    if (!drive_now)                          run_c = '0;
    else if (pat != pat_q)                   run_c = RW'(1);
    else if (run_q == RW'(BLANK_CYC + 1))    run_c = run_q;
    else                                     run_c = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_c;
  end

  AST_BLANK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (run_c == RW'(BLANK_CYC + 1))); // R4
  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chop_event_o |=> !chop_event_o); // R6
  AST_EVENT_STARTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    chop_event_o |-> chopping_o); // R5
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !chopping_o); // R9
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbc_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int OFF_NS   = 20_000,
  parameter int BLANK_NS = 3_750,
  parameter int DT       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in1_i,
  input  logic in2_i,
  input  logic disable_i,
  input  logic trip_i,
  output logic a_hi_o,
  output logic a_lo_o,
  output logic b_hi_o,
  output logic b_lo_o,
  output logic chop_event_o
);
  localparam int unsigned OFF_CYC   = ns_to_cycles(longint'(CLK_HZ), longint'(OFF_NS));
  localparam int unsigned BLANK_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(BLANK_NS));

  // Synchronised pins: {disable, in1, in2, trip}; disable resets asserted.
  logic [3:0] pins_s;
  logic       dis_s;
  logic       trip_s;
  cmd_e       cmd;
  logic       chopping;
  logic       event_w;

  hbc_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({disable_i, in1_i, in2_i, trip_i}),
    .q_o   (pins_s)
  );

  assign dis_s  = pins_s[3];
  assign cmd    = decode_pins(pins_s[2], pins_s[1]);
  assign trip_s = pins_s[0];

  leg_e       tgt [2];
  leg_e       st  [2];
  logic [1:0] hi_w;
  logic [1:0] lo_w;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    assign tgt[g] = leg_target(cmd, (g == 1), chopping, dis_s);
    hbc_leg #(.DT(DT)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .target_i (tgt[g]),
      .hi_en_o  (hi_w[g]),
      .lo_en_o  (lo_w[g]),
      .state_o  (st[g])
    );
  end

  hbc_chop #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_chop (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd),
    .halt_i       (dis_s),
    .trip_i       (trip_s),
    .a_state_i    (st[0]),
    .b_state_i    (st[1]),
    .chopping_o   (chopping),
    .chop_event_o (event_w)
  );

  // The raw disable pin masks the gates without waiting for the synchroniser.
  assign a_hi_o       = hi_w[0] & ~disable_i;
  assign a_lo_o       = lo_w[0] & ~disable_i;
  assign b_hi_o       = hi_w[1] & ~disable_i;
  assign b_lo_o       = lo_w[1] & ~disable_i;
  assign chop_event_o = event_w;

  AST_DECAY_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chopping) && chopping) |-> (!hi_w[0] && !hi_w[1])); // R5
  AST_HALT_LEGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_s) |-> (hi_w == 2'b00 && lo_w == 2'b00)); // R10
endmodule

// File: tb/tb_hbridge_chopper.sv
module tb_hbridge_chopper;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 4_000_000;
  localparam int DT   = 3;
  // Expected windows, restated as whole-kilohertz arithmetic.
  localparam int OFF_E   = (HZ / 1000) * 20_000 / 1_000_000;
  localparam int BLANK_E = (HZ / 1000) * 3_750 / 1_000_000;

  logic clk = 0;
  logic rst_n = 0;
  logic in1 = 0, in2 = 0, dis = 0, trip = 0;
  logic a_hi, a_lo, b_hi, b_lo, ev;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_chopper #(.CLK_HZ(HZ), .DT(DT)) dut (
    .clk(clk), .rst_n(rst_n), .in1_i(in1), .in2_i(in2), .disable_i(dis),
    .trip_i(trip), .a_hi_o(a_hi), .a_lo_o(a_lo), .b_hi_o(b_hi), .b_lo_o(b_lo),
    .chop_event_o(ev)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {a_hi, a_lo, b_hi, b_lo};
  endfunction

  // Expected {a_hi,a_lo,b_hi,b_lo} for a settled command.
  function automatic int exp_pat(int code);
    case (code)
      0: return 4'b0000;
      2: return 4'b1001;
      1: return 4'b0110;
      default: return 4'b0101;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input int code);
    in1 = code[1];
    in2 = code[0];
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R3 port monitor: dead-time gap and no direct swap on each leg.
  int  gap_a = 0, gap_b = 0;
  bit  seen_a = 0, seen_b = 0, p_ahi = 0, p_alo = 0, p_bhi = 0, p_blo = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (a_hi && a_lo) chk(0, "R3 leg A both on", 1, 0);
      if (b_hi && b_lo) chk(0, "R3 leg B both on", 1, 0);
      if ((a_hi && p_alo) || (a_lo && p_ahi)) chk(0, "R3 leg A direct swap", 1, 0);
      if ((b_hi && p_blo) || (b_lo && p_bhi)) chk(0, "R3 leg B direct swap", 1, 0);
      if ((a_hi || a_lo) && !(p_ahi || p_alo) && seen_a) chk(gap_a >= DT, "R3 leg A gap", gap_a, DT);
      if ((b_hi || b_lo) && !(p_bhi || p_blo) && seen_b) chk(gap_b >= DT, "R3 leg B gap", gap_b, DT);
      gap_a = (a_hi || a_lo) ? 0 : gap_a + 1;
      gap_b = (b_hi || b_lo) ? 0 : gap_b + 1;
      seen_a = seen_a | a_hi | a_lo;
      seen_b = seen_b | b_hi | b_lo;
      p_ahi = a_hi; p_alo = a_lo; p_bhi = b_hi; p_blo = b_lo;
    end
  end

  initial begin
    #(CLK_PERIOD * 150_000);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    // R1: reset state
    step(3);
    chk(outs() == 0 && ev == 0, "R1 during reset", outs(), 0);
    rst_n = 1;
    step(6);
    chk(outs() == 0 && ev == 0, "R1 after reset", outs(), 0);

    // R11: synchroniser latency from idle coast
    set_cmd(2);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(outs() == 0, "R11 not yet after two edges", outs(), 0);
    @(posedge clk); @(negedge clk);
    chk(outs() == exp_pat(2), "R11 visible after third edge", outs(), exp_pat(2));
    set_cmd(0);
    step(15);

    // R2: every ordered command transition
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        set_cmd(f); step(15);
        set_cmd(t); step(15);
        chk(outs() == exp_pat(t), $sformatf("R2 %0d->%0d", f, t), outs(), exp_pat(t));
      end
    end

    // R4/R5/R6: forward with trip held high, measured over 400 cycles
    begin
      int t_hi0 = -1, t_ev = -1, t_off = -1, t_hi1 = -1;
      int n_ev = 0, run = 0, max_run = 0, exp_ev = 0;
      bit blo_ok = 1, mid_ok = 0, prev_ev = 0;
      set_cmd(0); step(15);
      trip = 1; step(5);
      set_cmd(2);
      for (int i = 0; i < 400; i++) begin
        step(1);
        if (t_hi0 < 0 && a_hi) t_hi0 = i;
        if (t_hi0 >= 0 && t_ev < 0 && ev) t_ev = i;
        if (t_hi0 >= 0 && t_off < 0 && !a_hi) t_off = i;
        if (t_off >= 0 && t_hi1 < 0 && a_hi) t_hi1 = i;
        if (t_hi0 >= 0 && !b_lo) blo_ok = 0;
        if (t_off >= 0 && i == t_off + OFF_E / 2)
          mid_ok = (outs() == 4'b0101);
        if (ev && !prev_ev) n_ev++;
        run = ev ? run + 1 : 0;
        if (run > max_run) max_run = run;
        prev_ev = ev;
      end
      chk(t_ev - t_hi0 == BLANK_E + 1, "R4 event delay after turn-on", t_ev - t_hi0, BLANK_E + 1);
      chk(t_off - t_hi0 == BLANK_E + 2, "R4 high-side on time under trip", t_off - t_hi0, BLANK_E + 2);
      chk(t_hi1 - t_off == OFF_E + DT + 1, "R5 high-side off time", t_hi1 - t_off, OFF_E + DT + 1);
      chk(mid_ok, "R5 both low sides on mid off-time", outs(), 4'b0101);
      chk(blo_ok, "R5 leg B low side held", 0, 1);
      for (int k = 0; t_hi0 + BLANK_E + 1 + k * (BLANK_E + 2 + OFF_E + DT + 1) < 400; k++) exp_ev++;
      chk(n_ev == exp_ev, "R6 event count", n_ev, exp_ev);
      chk(max_run == 1, "R6 single-cycle pulse", max_run, 1);
    end

    // R7: trip ignored in coast and brake; trip low never chops
    begin
      int n_ev = 0;
      bit ok = 1;
      set_cmd(0); step(20);
      for (int i = 0; i < 300; i++) begin step(1); if (ev) n_ev++; if (outs() != 0) ok = 0; end
      set_cmd(3); step(20);
      for (int i = 0; i < 300; i++) begin step(1); if (ev) n_ev++; if (outs() != 4'b0101) ok = 0; end
      chk(n_ev == 0 && ok, "R7 trip in coast/brake", n_ev, 0);
      trip = 0; set_cmd(2); step(20);
      ok = 1;
      for (int i = 0; i < 300; i++) begin step(1); if (ev) n_ev++; if (outs() != 4'b1001) ok = 0; end
      chk(n_ev == 0 && ok, "R7 R6 trip low keeps drive", n_ev, 0);
    end

    // R8: external PWM on in1 with trip high
    begin
      int n_ev = 0;
      trip = 1; in2 = 0;
      for (int w = 0; w < 5; w++) begin
        in1 = 0;
        for (int i = 0; i < 30; i++) begin step(1); if (ev) n_ev++; end
        in1 = 1;
        for (int i = 0; i < 60; i++) begin step(1); if (ev) n_ev++; end
      end
      chk(n_ev == 5, "R8 one chop per PWM pulse", n_ev, 5);
    end

    // R9: brake then coast during the off time
    begin
      int n = 0;
      set_cmd(0); step(20);
      set_cmd(2);
      while (!ev && n < 100) begin step(1); n++; end
      trip = 0; step(5);
      set_cmd(3); step(10);
      chk(outs() == 4'b0101, "R9 brake during off time", outs(), 4'b0101);
      set_cmd(2); step(12);
      chk(outs() == 4'b1001, "R9 drive after brake abort", outs(), 4'b1001);
      trip = 1; n = 0;
      while (!ev && n < 100) begin step(1); n++; end
      trip = 0; step(5);
      set_cmd(0); step(8);
      chk(outs() == 0, "R9 coast during off time", outs(), 0);
      set_cmd(2); step(10);
      chk(outs() == 4'b1001, "R9 drive after coast abort", outs(), 4'b1001);
    end

    // R10: disable
    begin
      bit ok = 1;
      dis = 1; #1;
      chk(outs() == 0, "R10 immediate off", outs(), 0);
      for (int c = 0; c < 4; c++) begin
        set_cmd(c); trip = c[0]; step(4);
        if (outs() != 0 || ev) ok = 0;
      end
      chk(ok, "R10 inputs ignored while disabled", outs(), 0);
      set_cmd(1); trip = 0; step(2);
      dis = 0; step(15);
      chk(outs() == exp_pat(1), "R10 resumes current command", outs(), exp_pat(1));
    end

    step(5);
    summary();
  end
endmodule